// File: doc/BRIEF.md
# Overcurrent Message Debounce Filter

This block sits between the raw overcurrent comparators of eight high-side output channels and the interrupt logic. The channels form two groups of four: a lower group (channels 0 to 3) and an upper group (channels 4 to 7). A channel's raw flag is accepted as a real overcurrent only after it has stayed high for an unbroken run of system clock cycles. Each group can choose between a short window of about 2690 cycles and a long window of about 5380 cycles. A single configuration byte sets the two group windows and a global bypass. A separate mode input forces unfiltered operation, for systems that run without the filter clock.

Each qualified rising edge of a filtered flag sets a sticky per-channel message bit. Any set message bit raises the interrupt request. Software acknowledges by writing the configuration byte with its clear bit set. That bit is never stored. It empties every message bit in one cycle. A channel whose fault is still present stays filtered-high and is not reported again until its filtered flag falls and then qualifies again.

Top module: `ocp_debounce`

## Requirements
- R1: After a synchronous active-low reset, the configuration reads back 0x00 and all filtered flags, message bits and the interrupt request are 0.
- R2: A write stores bit 4 (upper-group long window), bit 3 (bypass) and bit 0 (lower-group long window). The readback presents these at the same positions and is valid from the cycle after the write. Bits 7, 6, 5, 2 and 1 always read 0.
- R3: With bypass off and mode input low, a lower-group channel's filtered flag goes high once its raw flag has been sampled high on 2690 consecutive clock edges when bit 0 is 0. With bit 0 set, 5379 consecutive edges are needed.
- R4: The upper group qualifies in the same way, with bit 4 choosing between 2690 and 5379 edges.
- R5: A raw flag sampled low restarts that channel's run count from zero. Any run shorter than the selected window leaves the filtered flag low.
- R6: With bit 3 set, every filtered flag follows its raw flag combinationally, in the same cycle.
- R7: With the no-filter mode input high, every filtered flag follows its raw flag combinationally, whatever the bypass bit holds.
- R8: A 0-to-1 change of a filtered flag sets that channel's message bit on the next clock edge. The interrupt request is high whenever any message bit is set.
- R9: A write with bit 7 set clears all message bits on that edge, except bits whose filtered flag rises in the same cycle. A filtered flag that stays high after the clear does not set its bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the qualification windows |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_oc | input | 8 | Raw overcurrent flags; bit n is channel n, channels 0-3 form the lower group |
| filt_off | input | 1 | No-filter mode: flags pass unfiltered while high |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration write data (bits 7, 4, 3, 0 used) |
| cfg_rdata | output | 8 | Configuration readback |
| oc_filt | output | 8 | Filtered overcurrent flags |
| oc_msg | output | 8 | Sticky per-channel overcurrent messages |
| irq | output | 1 | Interrupt request, OR of all message bits |

## Verification
A filtered flag is due on the negative edge that follows the 2690th (or 5379th) rising edge at which its raw flag is sampled high. In bypass or no-filter mode, the filtered flag is due within the same cycle the raw flag changes. A message bit and the interrupt request appear one edge after their filtered flag rises. The readback and a clear take effect one edge after the write. The reference model advances its run counts and message bits on each rising edge from the inputs driven half a cycle earlier, and compares all outputs on every falling edge. Directed checks sample one edge before and at each window boundary, so an off-by-one length or a late latch is caught.

// File: rtl/ocpf_pkg.sv
// Shared definitions for the overcurrent debounce filter.
// Assumes an 8-bit configuration byte with fixed bit meanings.
package ocpf_pkg;
    localparam int CLR_BIT = 7;
    localparam int HI_BIT  = 4;
    localparam int BYP_BIT = 3;
    localparam int LO_BIT  = 0;

    typedef struct packed {
        logic long_hi;
        logic bypass;
        logic long_lo;
    } ocpf_cfg_t;
endpackage

// File: rtl/ocpf_cfg_reg.sv
// Configuration byte: stores the two window selects and the bypass,
// turns bit 7 of a write into a one-cycle clear pulse, and builds
// the readback with unused bits tied low.
// Assumes a single-cycle write strobe.
module ocpf_cfg_reg
    import ocpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ocpf_cfg_t  cfg,
    output logic       clr_pulse,
    output logic [7:0] rdata
);

    // Capture the stored fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.long_hi <= wdata[HI_BIT];
            cfg.bypass  <= wdata[BYP_BIT];
            cfg.long_lo <= wdata[LO_BIT];
        end
    end

    // Clear bit acts on the write cycle only and is never held.
    assign clr_pulse = we & wdata[CLR_BIT];

    // Readback: stored fields at their write positions, rest zero.
    always_comb begin
        rdata          = '0;
        rdata[HI_BIT]  = cfg.long_hi;
        rdata[BYP_BIT] = cfg.bypass;
        rdata[LO_BIT]  = cfg.long_lo;
    end

    // R2
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[HI_BIT] == $past(wdata[HI_BIT])) &&
               (rdata[BYP_BIT] == $past(wdata[BYP_BIT])) &&
               (rdata[LO_BIT] == $past(wdata[LO_BIT])));

endmodule

// File: rtl/ocpf_chan.sv
// One channel's run-length filter: counts consecutive high samples of
// the raw flag, saturating at the long window, and reports the flag as
// filtered once the count reaches the selected window.
// Assumes SHORT_CNT < LONG_CNT and that CNT_W can hold LONG_CNT.
module ocpf_chan #(
    parameter int SHORT_CNT = 2690,
    parameter int LONG_CNT  = 5379,
    parameter int CNT_W     = $clog2(LONG_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic long_sel,
    input  logic pass_raw,
    output logic filt
);

    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CNT);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CNT);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Run counter: restart on a low sample, saturate at the long window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!raw) begin
            cnt <= '0;
        end else if (cnt < LONG_LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Window choice and output mux between filtered and raw flag.
    assign limit = long_sel ? LONG_LIM : SHORT_LIM;
    assign filt  = pass_raw ? raw : (cnt >= limit);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> (cnt == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LONG_LIM);

    // R6
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_raw |-> (filt == raw));

endmodule

// File: rtl/ocpf_msg_latch.sv
// Sticky message bits: a rising filtered flag sets its bit, a clear
// pulse empties all bits (a same-cycle rise wins), irq is their OR.
// Assumes filtered flags are synchronous to clk.
module ocpf_msg_latch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] filt,
    input  logic           clr,
    output logic [NCH-1:0] msg,
    output logic           irq
);

    logic [NCH-1:0] filt_d;
    logic [NCH-1:0] rise;

    // Edge detector history and sticky message update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_d <= '0;
            msg    <= '0;
        end else begin
            filt_d <= filt;
            msg    <= (msg & ~{NCH{clr}}) | rise;
        end
    end

    // Rising edges of the filtered flags and the request summary.
    assign rise = filt & ~filt_d;
    assign irq  = |msg;

    // R8
    msg_needs_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((msg & ~$past(msg) & ~$past(filt)) == '0));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((msg & ~$past(filt)) == '0));

endmodule

// File: rtl/ocp_debounce.sv
// Top of the overcurrent debounce filter: one run-length filter per
// channel, two channel groups with their own window select, a shared
// bypass, and the sticky message latch with interrupt request.
// Assumes raw flags are already synchronous to clk.
module ocp_debounce
    import ocpf_pkg::*;
#(
    parameter int GRP_W     = 4,
    parameter int SHORT_CNT = 2690,
    parameter int LONG_CNT  = 5379,
    localparam int NCH      = 2 * GRP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_oc,
    input  logic           filt_off,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic [NCH-1:0] oc_filt,
    output logic [NCH-1:0] oc_msg,
    output logic           irq
);

    ocpf_cfg_t cfg;
    logic      clr_pulse;
    logic      pass_raw;

    ocpf_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .cfg       (cfg),
        .clr_pulse (clr_pulse),
        .rdata     (cfg_rdata)
    );

    // Either bypass source sends the raw flags straight through.
    assign pass_raw = cfg.bypass | filt_off;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam bit UPPER = (ch >= GRP_W);
        ocpf_chan #(
            .SHORT_CNT (SHORT_CNT),
            .LONG_CNT  (LONG_CNT)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (raw_oc[ch]),
            .long_sel (UPPER ? cfg.long_hi : cfg.long_lo),
            .pass_raw (pass_raw),
            .filt     (oc_filt[ch])
        );
    end

    ocpf_msg_latch #(.NCH(NCH)) u_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .filt  (oc_filt),
        .clr   (clr_pulse),
        .msg   (oc_msg),
        .irq   (irq)
    );

    // R7
    nofilt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_off |-> (oc_filt == raw_oc));

endmodule

// File: tb/sim_ocp_debounce.sv
module sim_ocp_debounce;
    localparam int SHORT = 2690;
    localparam int LONG  = 5379;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] raw_oc = '0;
    logic       filt_off = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata, oc_filt, oc_msg;
    logic       irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    int run [8];
    bit prev [8];
    bit [7:0] m_msg;
    bit m_hi, m_byp, m_lo;

    always #5 clk = ~clk;

    ocp_debounce u0 (
        .clk(clk), .rst_n(rst_n), .raw_oc(raw_oc), .filt_off(filt_off),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .oc_filt(oc_filt), .oc_msg(oc_msg), .irq(irq)
    );

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic bit m_eff(int ch);
        int lim;
        if (m_byp || filt_off) return raw_oc[ch];
        lim = ((ch >= 4) ? m_hi : m_lo) ? LONG : SHORT;
        return run[ch] >= lim;
    endfunction

    function automatic bit [7:0] m_filt();
        bit [7:0] f;
        for (int ch = 0; ch < 8; ch++) f[ch] = m_eff(ch);
        return f;
    endfunction

    // reference model advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 8; ch++) begin run[ch] = 0; prev[ch] = 0; end
            m_msg = '0; m_hi = 0; m_byp = 0; m_lo = 0;
        end else begin
            bit [7:0] e;
            e = m_filt();
            if (cfg_we && cfg_wdata[7]) m_msg = '0;
            for (int ch = 0; ch < 8; ch++) begin
                if (e[ch] && !prev[ch]) m_msg[ch] = 1'b1;
                prev[ch] = e[ch];
                if (raw_oc[ch]) begin
                    if (run[ch] < 100000) run[ch]++;
                end else run[ch] = 0;
            end
            if (cfg_we) begin
                m_hi = cfg_wdata[4]; m_byp = cfg_wdata[3]; m_lo = cfg_wdata[0];
            end
        end
    end

    // compare every cycle on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 cfg_rdata", cfg_rdata, {3'b0, m_hi, m_byp, 2'b0, m_lo});
            chk("R3 R4 R5 R6 R7 oc_filt", oc_filt, m_filt());
            chk("R8 R9 oc_msg", oc_msg, m_msg);
            chk("R8 irq", irq, |m_msg);
        end
    end

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        edges(1);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 filt", oc_filt, 0);
        chk("R1 msg", oc_msg, 0);
        chk("R1 irq", irq, 0);

        // R2 unused bits and clear bit read 0
        wr(8'hFF);
        chk("R2 readback", cfg_rdata, 8'h19);
        wr(8'h00);
        chk("R2 readback zero", cfg_rdata, 8'h00);

        // R3 short lower window, R8 message one edge later
        raw_oc[0] = 1'b1;
        edges(SHORT - 1);
        chk("R3 short before", oc_filt[0], 0);
        edges(1);
        chk("R3 short at", oc_filt[0], 1);
        chk("R8 msg not yet", oc_msg[0], 0);
        edges(1);
        chk("R8 msg set", oc_msg[0], 1);
        chk("R8 irq set", irq, 1);

        // R5 a single low sample restarts the run
        raw_oc[1] = 1'b1;
        edges(1000);
        raw_oc[1] = 1'b0;
        edges(1);
        raw_oc[1] = 1'b1;
        edges(SHORT - 1);
        chk("R5 restarted", oc_filt[1], 0);
        edges(1);
        chk("R5 requalified", oc_filt[1], 1);
        edges(1);

        // R9 clear while faults persist: no re-set
        wr(8'h80);
        chk("R9 cleared", oc_msg, 0);
        chk("R9 irq cleared", irq, 0);
        chk("R9 clear bit reads 0", cfg_rdata, 0);
        edges(5);
        chk("R9 no re-set", oc_msg, 0);
        raw_oc[0] = 1'b0;
        edges(1);
        raw_oc[0] = 1'b1;
        edges(SHORT + 1);
        chk("R9 sets on new qualification", oc_msg[0], 1);

        // R3 long lower window
        wr(8'h01);
        raw_oc[2] = 1'b1;
        edges(SHORT);
        chk("R3 long not yet", oc_filt[2], 0);
        edges(LONG - SHORT - 1);
        chk("R3 long before", oc_filt[2], 0);
        edges(1);
        chk("R3 long at", oc_filt[2], 1);

        // R4 upper group short, then long
        raw_oc[5] = 1'b1;
        edges(SHORT - 1);
        chk("R4 short before", oc_filt[5], 0);
        edges(1);
        chk("R4 short at", oc_filt[5], 1);
        wr(8'h11);
        raw_oc[6] = 1'b1;
        edges(SHORT);
        chk("R4 long not yet", oc_filt[6], 0);
        edges(LONG - SHORT - 1);
        chk("R4 long before", oc_filt[6], 0);
        edges(1);
        chk("R4 long at", oc_filt[6], 1);

        // R6 bypass follows raw in the same cycle
        wr(8'h08);
        raw_oc[7] = 1'b1;
        #1;
        chk("R6 bypass high", oc_filt[7], 1);
        edges(1);
        chk("R8 bypass msg", oc_msg[7], 1);
        raw_oc[7] = 1'b0;
        #1;
        chk("R6 bypass low", oc_filt[7], 0);
        wr(8'h00);

        // R7 no-filter mode follows raw
        edges(2);
        filt_off = 1'b1;
        raw_oc[4] = 1'b1;
        #1;
        chk("R7 nofilt high", oc_filt[4], 1);
        edges(1);
        raw_oc[4] = 1'b0;
        #1;
        chk("R7 nofilt low", oc_filt[4], 0);
        filt_off = 1'b0;
        edges(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule